// File: doc/BRIEF.md
# Failsafe Command Activity Monitor

This block sits between the general-purpose outputs of a small processor and an actuator or power stage whose safe condition is "on". Firmware proves it is alive by toggling a heartbeat line and by presenting a 4-bit command code. A held level on the heartbeat, at either 0 or 1, counts as a dead command. So does any code outside the two legal patterns. When either happens, hardwired logic takes the actuator output, forces it on, raises a sticky fault flag and issues a one-cycle reboot request to the processor.

Both the heartbeat and the code are synchronized through two flops before they are used. The block leaves reset in the failsafe state. It hands control back to firmware only after a run of heartbeat edges, all seen while the code is legal. While firmware is in control, the actuator follows the code.

Top module: `failsafe_cmd_monitor`

## Requirements
- R1: While reset is held and on the first cycle after it, the block is in the failsafe state: `act_on_o` is 1, `fault_o` is 0 and `reboot_req_o` is 0.
- R2: The block leaves the failsafe state only after `ARM_EDGES` (default 4) consecutive synchronized heartbeat edges, each seen with a legal code. An illegal code or a heartbeat timeout during the run restarts the count, and fewer edges leave the actuator on.
- R3: While firmware is in control, code 4'b1010 drives `act_on_o` to 0 and code 4'b0101 drives it to 1.
- R4: A heartbeat held at 0 for `TIMEOUT_CYC` (default 16) cycles or more puts the block into the failsafe state.
- R5: A heartbeat held at 1 for `TIMEOUT_CYC` cycles or more puts the block into the failsafe state.
- R6: Any code other than 4'b1010 or 4'b0101 puts the block into the failsafe state.
- R7: A heartbeat whose edges are `TIMEOUT_CYC`-1 cycles apart keeps firmware in control. Edges `TIMEOUT_CYC`+1 cycles apart cause a failure.
- R8: `reboot_req_o` is a one-cycle pulse, issued exactly once each time the block moves from firmware control to the failsafe state. No pulse is issued at reset or while the block stays failed.
- R9: `fault_o` is set when a failure is entered. It remains set after recovery until `fault_clr_i` is pulsed.
- R10: In the failsafe state `act_on_o` is 1 whatever the code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| beat_i | input | 1 | Heartbeat from firmware; must keep toggling |
| cmd_code_i | input | 4 | Encoded actuator command from firmware |
| fault_clr_i | input | 1 | Clears the sticky fault flag |
| act_on_o | output | 1 | Actuator enable (1 = on, the safe state) |
| fault_o | output | 1 | Sticky record that a failure occurred |
| reboot_req_o | output | 1 | One-cycle request for a processor reboot |

## Verification
The hardest case to reach is a partially armed recovery: the block is failed and has counted some good edges, but not enough, when the heartbeat stops again. The stimulus table leaves the block failed under a heartbeat that is slightly too slow, so the edge count is bounded. It then supplies a single toggle and a hold. This shows that the count is dropped and no fresh reboot pulse appears. Timeout boundaries are reached by toggling with periods one cycle either side of the window.

// File: rtl/failsafe_cmd_monitor.sv
module failsafe_cmd_monitor #(
  parameter int         TIMEOUT_CYC = 16,
  parameter int         ARM_EDGES   = 4,
  parameter logic [3:0] CODE_OFF    = 4'b1010,
  parameter logic [3:0] CODE_ON     = 4'b0101
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       beat_i,
  input  logic [3:0] cmd_code_i,
  input  logic       fault_clr_i,
  output logic       act_on_o,
  output logic       fault_o,
  output logic       reboot_req_o
);
  localparam int TW = $clog2(TIMEOUT_CYC + 1);
  localparam int AW = $clog2(ARM_EDGES + 1);

  logic          beat_s1, beat_s2, beat_d;
  logic [3:0]    code_s1, code_s2;
  logic [TW-1:0] quiet;
  logic [AW-1:0] armc;
  logic          failed, reboot_q, fault_q;

  wire beat_edge = beat_s2 ^ beat_d;
  wire code_ok   = (code_s2 == CODE_OFF) || (code_s2 == CODE_ON);
  wire stall     = !beat_edge && (quiet == TW'(TIMEOUT_CYC - 1));
  wire trip      = !failed && (stall || !code_ok);
  wire arm_done  = failed && beat_edge && code_ok && (armc == AW'(ARM_EDGES - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      beat_s1 <= 1'b0;
      beat_s2 <= 1'b0;
      beat_d  <= 1'b0;
      code_s1 <= '0;
      code_s2 <= '0;
    end else begin
      beat_s1 <= beat_i;
      beat_s2 <= beat_s1;
      beat_d  <= beat_s2;
      code_s1 <= cmd_code_i;
      code_s2 <= code_s1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 quiet <= '0;
    else if (beat_edge || stall) quiet <= '0;
    else                        quiet <= quiet + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                       armc <= '0;
    else if (!failed || arm_done)     armc <= '0;
    else if (!code_ok || stall)       armc <= '0;
    else if (beat_edge)               armc <= armc + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      failed   <= 1'b1;
      reboot_q <= 1'b0;
      fault_q  <= 1'b0;
    end else begin
      reboot_q <= trip;
      if (trip)          failed <= 1'b1;
      else if (arm_done) failed <= 1'b0;
      if (trip)             fault_q <= 1'b1;
      else if (fault_clr_i) fault_q <= 1'b0;
    end
  end

  assign act_on_o     = failed || (code_s2 != CODE_OFF);
  assign fault_o      = fault_q;
  assign reboot_req_o = reboot_q;
endmodule

// File: rtl/failsafe_cmd_monitor_chk.sv
module failsafe_cmd_monitor_chk #(
  parameter logic [3:0] CODE_OFF = 4'b1010,
  parameter logic [3:0] CODE_ON  = 4'b0101
) (
  input logic       clk,
  input logic       rst_n,
  input logic       failed,
  input logic [3:0] code_s2,
  input logic       fault_o,
  input logic       reboot_req_o,
  input logic       fault_clr_i
);
  p_entry_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(failed) |-> reboot_req_o);

  p_single_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    reboot_req_o |=> !reboot_req_o);

  p_pulse_flags_r9: assert property (@(posedge clk) disable iff (!rst_n)
    reboot_req_o |-> fault_o);

  p_fault_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (fault_o && !fault_clr_i) |=> fault_o);

  p_illegal_trips_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!failed && code_s2 != CODE_OFF && code_s2 != CODE_ON) |=> failed);
endmodule

bind failsafe_cmd_monitor failsafe_cmd_monitor_chk #(
  .CODE_OFF(CODE_OFF),
  .CODE_ON (CODE_ON)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .failed      (failed),
  .code_s2     (code_s2),
  .fault_o     (fault_o),
  .reboot_req_o(reboot_req_o),
  .fault_clr_i (fault_clr_i)
);

// File: tb/failsafe_cmd_monitor_bench.sv
module failsafe_cmd_monitor_bench;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 14;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       beat = 1'b0;
  logic       clr = 1'b0;
  logic [3:0] code = 4'b0000;
  logic       act, fault, rb;

  int checks = 0;
  int fails = 0;
  int rb_seen = 0;

  failsafe_cmd_monitor u_failsafe_cmd_monitor (
    .clk(clk), .rst_n(rst_n), .beat_i(beat), .cmd_code_i(code),
    .fault_clr_i(clr), .act_on_o(act), .fault_o(fault), .reboot_req_o(rb)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // {req[4], code[4], hold level, toggle period (0 = hold), cycles, act, fault, reboots[2]}
  localparam logic [28:0] VEC [NVEC] = '{
    {4'd2,  4'b1010, 1'b0, 8'd3,  8'd40, 1'b0, 1'b0, 2'd0},  // R2 arm from reset
    {4'd3,  4'b0101, 1'b0, 8'd3,  8'd20, 1'b1, 1'b0, 2'd0},  // R3 command on
    {4'd3,  4'b1010, 1'b0, 8'd3,  8'd20, 1'b0, 1'b0, 2'd0},  // R3 command off
    {4'd4,  4'b1010, 1'b0, 8'd0,  8'd60, 1'b1, 1'b1, 2'd1},  // R4 R8 stuck low
    {4'd9,  4'b1010, 1'b0, 8'd3,  8'd40, 1'b0, 1'b1, 2'd0},  // R9 recover, flag kept
    {4'd5,  4'b1010, 1'b1, 8'd0,  8'd40, 1'b1, 1'b1, 2'd1},  // R5 R10 stuck high
    {4'd2,  4'b1010, 1'b0, 8'd3,  8'd40, 1'b0, 1'b1, 2'd0},  // R2 recover
    {4'd6,  4'b1011, 1'b0, 8'd3,  8'd12, 1'b1, 1'b1, 2'd1},  // R6 illegal code
    {4'd2,  4'b1010, 1'b0, 8'd3,  8'd40, 1'b0, 1'b1, 2'd0},  // R2 recover
    {4'd7,  4'b1010, 1'b0, 8'd15, 8'd80, 1'b0, 1'b1, 2'd0},  // R7 gap just inside window
    {4'd7,  4'b1010, 1'b0, 8'd17, 8'd80, 1'b1, 1'b1, 2'd1},  // R7 gap just outside window
    {4'd2,  4'b1010, 1'b0, 8'd3,  8'd2,  1'b1, 1'b1, 2'd0},  // R2 partial arming only
    {4'd10, 4'b1010, 1'b0, 8'd0,  8'd30, 1'b1, 1'b1, 2'd0},  // R10 R8 stays failed, no pulse
    {4'd2,  4'b1010, 1'b0, 8'd3,  8'd40, 1'b0, 1'b1, 2'd0}   // R2 full recovery
  };

  task automatic expect_eq(input string tag, input int got, input int exp);
    checks++;
    if (got != exp) begin
      fails++;
      $display("FAIL %s actual %0d expected %0d", tag, got, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
    if (rb === 1'b1) rb_seen++;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    checks++;
    fails++;
    $display("FAIL watchdog expired actual 0 expected 1");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    logic [28:0] v;
    repeat (3) tick();
    rst_n = 1'b1;
    rb_seen = 0;
    tick();
    expect_eq("R1 act after reset", int'(act), 1);
    expect_eq("R1 fault after reset", int'(fault), 0);
    expect_eq("R1 reboot after reset", rb_seen, 0);

    for (int i = 0; i < NVEC; i++) begin
      v = VEC[i];
      rb_seen = 0;
      for (int c = 0; c < int'(v[11:4]); c++) begin
        tick();
        code = v[24:21];
        if (v[19:12] != 8'd0) begin
          if (c % int'(v[19:12]) == 0) beat = ~beat;
        end else begin
          beat = v[20];
        end
      end
      tick();
      expect_eq($sformatf("R%0d vec %0d act", v[28:25], i), int'(act), int'(v[3]));
      expect_eq($sformatf("R%0d vec %0d fault", v[28:25], i), int'(fault), int'(v[2]));
      expect_eq($sformatf("R%0d vec %0d reboots", v[28:25], i), rb_seen, int'(v[1:0]));
    end

    // R9 clear pulse drops the sticky flag without disturbing control
    tick();
    clr = 1'b1;
    beat = ~beat;
    tick();
    clr = 1'b0;
    tick();
    expect_eq("R9 fault after clear", int'(fault), 0);
    expect_eq("R9 act after clear", int'(act), 0);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule